// File: doc/BRIEF.md
# Predicated Vector Expand Unit

This datapath block spreads the low-numbered elements of a source vector over the active lanes of a destination vector. The lanes are walked from lowest to highest. Each active lane takes the next source element that has not been used yet, starting at source element 0. Every inactive lane is written with zero.

The element width is picked per operation by a 2-bit size code, and the vector length is a synthesis parameter. Activity is taken from a predicate that carries one bit per byte of the vector. For each destination lane, the block computes an exclusive prefix count of the active lanes below it. That count is the index of the source element the lane receives.

An operation is presented as a valid-qualified bundle of source vector, predicate and size code. The result appears in a register one clock later, with its own valid flag.

Top module: `pred_expand`

## Requirements
- R1: The size code sets the element width: code 0 gives 8 bits, code 1 gives 16, code 2 gives 32 and code 3 gives 64. The lane count is the vector length divided by that width, and lane e occupies bits [e*width +: width].
- R2: A lane is active exactly when the predicate bit at byte index (lane index × element bytes) is 1. All other predicate bits inside the lane are ignored.
- R3: Taken in increasing lane order, the k-th active lane (counting from 0) receives source element k.
- R4: Every inactive lane of the result is all zeros.
- R5: A predicate with no active lane for the chosen size gives an all-zero result.
- R6: Source elements whose index is at or above the number of active lanes do not affect the result.
- R7: The result of an input accepted with in_valid high appears on out_vec after the next rising clock edge, and out_valid equals in_valid delayed by one cycle.
- R8: While in_valid is low, out_vec keeps its previous value.
- R9: Synchronous active-high reset clears out_valid and out_vec to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input bundle valid |
| in_src | input | VLEN | Source vector |
| in_pred | input | VLEN/8 | Predicate, one bit per byte |
| in_size | input | 2 | Element size code |
| out_valid | output | 1 | Result valid |
| out_vec | output | VLEN | Registered result vector |

## Verification
The bench builds the unit at its default vector length of 256 bits. At that length there are 32, 16, 8 or 4 lanes, so every element size can be exercised in one build.

With only four 64-bit lanes, random predicates cover all sixteen lane-activity patterns. At 8-bit elements, the 32-lane prefix count is pushed to long runs of active lanes and to sparse patterns. Predicates that set only the non-leading bits of each lane check that those bits are ignored.

Source tails beyond the active count are altered to check that they have no effect on the result.

// File: rtl/pexp_pkg.sv
package pexp_pkg;

  typedef enum logic [1:0] {
    ESZ_8  = 2'd0,
    ESZ_16 = 2'd1,
    ESZ_32 = 2'd2,
    ESZ_64 = 2'd3
  } esize_e;

  localparam int unsigned NUM_SIZES = 4;

  function automatic int unsigned elem_bytes(input int unsigned code);
    return 1 << code;
  endfunction

endpackage

// File: rtl/pexp_prefix_cnt.sv
module pexp_prefix_cnt #(
  parameter int unsigned LANES = 32,
  parameter int unsigned IW    = $clog2(LANES) + 1
) (
  input  logic [LANES-1:0]    act,
  output logic [LANES*IW-1:0] idx
);

  logic [IW-1:0] run;

  // Exclusive running count of the active lanes below each lane.
  always_comb begin
    run = '0;
    idx = '0;
    for (int e = 0; e < LANES; e++) begin
      idx[e*IW +: IW] = run;
      run = run + IW'(act[e]);
    end
  end

endmodule

// File: rtl/pexp_lane_route.sv
module pexp_lane_route #(
  parameter int unsigned LANES = 32,
  parameter int unsigned EW    = 8,
  parameter int unsigned IW    = $clog2(LANES) + 1
) (
  input  logic [LANES*EW-1:0] src,
  input  logic [LANES-1:0]    act,
  input  logic [LANES*IW-1:0] idx,
  output logic [LANES*EW-1:0] res
);

  always_comb begin
    res = '0;
    for (int e = 0; e < LANES; e++) begin
      if (act[e]) begin
        for (int k = 0; k < LANES; k++) begin
          // Only the lanes at or above k can need source element k.
          if (k <= e && idx[e*IW +: IW] == IW'(k)) begin
            res[e*EW +: EW] = src[k*EW +: EW];
          end
        end
      end
    end
  end

endmodule

// File: rtl/pred_expand.sv
module pred_expand #(
  parameter int unsigned VLEN = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [VLEN-1:0]   in_src,
  input  logic [VLEN/8-1:0] in_pred,
  input  logic [1:0]        in_size,
  output logic              out_valid,
  output logic [VLEN-1:0]   out_vec
);
  import pexp_pkg::*;

  localparam int unsigned NBYTES = VLEN / 8;

  logic [VLEN-1:0] res_by_size [NUM_SIZES];
  logic [VLEN-1:0] res_sel;

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    localparam int unsigned EB = elem_bytes(s);
    localparam int unsigned EW = 8 * EB;
    localparam int unsigned LN = NBYTES / EB;
    localparam int unsigned IW = $clog2(LN) + 1;

    logic [LN-1:0]    act;
    logic [LN*IW-1:0] idx;
    logic [VLEN-1:0]  res;

    // Activity comes from the predicate bit at the lowest byte of each lane.
    for (genvar e = 0; e < LN; e++) begin : g_act
      assign act[e] = in_pred[e*EB];
    end

    pexp_prefix_cnt #(
      .LANES(LN),
      .IW   (IW)
    ) u_cnt (
      .act(act),
      .idx(idx)
    );

    pexp_lane_route #(
      .LANES(LN),
      .EW   (EW),
      .IW   (IW)
    ) u_route (
      .src(in_src),
      .act(act),
      .idx(idx),
      .res(res)
    );

    assign res_by_size[s] = res;
  end

  always_comb begin
    unique case (esize_e'(in_size))
      ESZ_8:   res_sel = res_by_size[0];
      ESZ_16:  res_sel = res_by_size[1];
      ESZ_32:  res_sel = res_by_size[2];
      default: res_sel = res_by_size[3];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_vec   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_vec <= res_sel;
      end
    end
  end

endmodule

// File: rtl/pred_expand_chk.sv
module pred_expand_chk #(
  parameter int unsigned VLEN = 256
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [7:0]        in_src_b0,
  input logic [VLEN/8-1:0] in_pred,
  input logic              out_valid,
  input logic [VLEN-1:0]   out_vec
);

  // R7: output valid trails input valid by one cycle
  a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r7_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R8: result register holds while no input is accepted
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_vec));

  // R9: reset empties the output stage
  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && out_vec == '0));

  // R4: lane 0 inactive gives a zero low byte at every size
  a_r4_lane0_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_pred[0]) |=> (out_vec[7:0] == 8'h00));

  // R3: lane 0 active takes source element 0
  a_r3_lane0_first: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_pred[0]) |=> (out_vec[7:0] == $past(in_src_b0)));

  // R5: an empty predicate yields an empty result
  a_r5_empty_pred: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_pred == '0) |=> (out_vec == '0));

endmodule

bind pred_expand pred_expand_chk #(.VLEN(VLEN)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_src_b0(in_src[7:0]),
  .in_pred  (in_pred),
  .out_valid(out_valid),
  .out_vec  (out_vec)
);

// File: tb/pred_expand_tb_top.sv
module pred_expand_tb_top;

  localparam int VLEN = 256;
  localparam int PW   = VLEN / 8;

  logic            clk = 1'b0;
  logic            rst;
  logic            in_valid;
  logic [VLEN-1:0] in_src;
  logic [PW-1:0]   in_pred;
  logic [1:0]      in_size;
  logic            out_valid;
  logic [VLEN-1:0] out_vec;

  logic            exp_valid;
  logic [VLEN-1:0] exp_vec;
  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  pred_expand #(.VLEN(VLEN)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_src(in_src),
    .in_pred(in_pred), .in_size(in_size),
    .out_valid(out_valid), .out_vec(out_vec)
  );

  function automatic logic [VLEN-1:0] rnd_vec();
    logic [VLEN-1:0] v;
    for (int i = 0; i < VLEN / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [PW-1:0] rnd_pred();
    logic [PW-1:0] p;
    for (int i = 0; i < PW; i++) p[i] = $urandom_range(0, 1);
    return p;
  endfunction

  // Behavioural lane walk, written from the requirements.
  function automatic logic [VLEN-1:0] model(logic [VLEN-1:0] src,
                                            logic [PW-1:0] pred, int sz);
    logic [VLEN-1:0] r;
    int eb = 1 << sz;
    int ew = 8 * eb;
    int x  = 0;
    r = '0;
    for (int e = 0; e < VLEN / ew; e++) begin
      if (pred[e*eb]) begin
        for (int b = 0; b < ew; b++) r[e*ew + b] = src[x*ew + b];
        x++;
      end
    end
    return r;
  endfunction

  function automatic int active_count(logic [PW-1:0] pred, int sz);
    int n = 0;
    for (int e = 0; e < PW >> sz; e++) if (pred[e << sz]) n++;
    return n;
  endfunction

  task automatic check(string tag);
    n_chk++;
    if (out_valid !== exp_valid || out_vec !== exp_vec) begin
      n_fail++;
      $display("FAIL %s: got valid=%0b vec=%h, expected valid=%0b vec=%h",
               tag, out_valid, out_vec, exp_valid, exp_vec);
    end
  endtask

  task automatic apply(bit v, logic [VLEN-1:0] src, logic [PW-1:0] pred,
                       int sz, string tag);
    in_valid = v;
    in_src   = src;
    in_pred  = pred;
    in_size  = 2'(sz);
    exp_valid = v;
    if (v) exp_vec = model(src, pred, sz);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    logic [VLEN-1:0] a, b, first;
    logic [PW-1:0]   p;
    int              n;
    rst = 1'b1; in_valid = 1'b0; in_src = '0; in_pred = '0; in_size = '0;
    repeat (3) @(negedge clk);
    exp_valid = 1'b0; exp_vec = '0;
    check("R9 reset state");
    rst = 1'b0;

    // R1 / R3: all lanes active at each size copies the source straight through
    for (int sz = 0; sz < 4; sz++) apply(1, rnd_vec(), '1, sz, "R1 full predicate");
    // R3: sparse single-lane and alternating patterns
    for (int sz = 0; sz < 4; sz++) begin
      apply(1, rnd_vec(), PW'(1) << ((PW >> sz) - 1 << sz), sz, "R3 top lane only");
      apply(1, rnd_vec(), {(PW/2){2'b10}}, sz, "R3 alternating");
    end
    // R2: only non-leading bits of each lane set -> nothing active
    p = '1;
    for (int i = 0; i < PW; i += 8) p[i] = 1'b0;
    apply(1, rnd_vec(), p, 3, "R2 non-leading bits ignored");
    for (int sz = 1; sz < 4; sz++) apply(1, rnd_vec(), rnd_pred(), sz, "R2 random");
    // R5: empty predicate
    for (int sz = 0; sz < 4; sz++) apply(1, rnd_vec(), '0, sz, "R5 empty predicate");
    // R4: inactive lanes zero under random predicates
    for (int i = 0; i < 40; i++) apply(1, rnd_vec(), rnd_pred(), i % 4, "R4 random");

    // R6: changing the unused source tail leaves the result unchanged
    for (int sz = 0; sz < 4; sz++) begin
      p = rnd_pred();
      n = active_count(p, sz);
      a = rnd_vec();
      b = rnd_vec();
      for (int i = 0; i < VLEN; i++) if (i < n * (8 << sz)) b[i] = a[i];
      apply(1, a, p, sz, "R6 first source");
      first = out_vec;
      apply(1, b, p, sz, "R6 altered tail");
      n_chk++;
      if (out_vec !== first) begin
        n_fail++;
        $display("FAIL R6: got %h, expected %h", out_vec, first);
      end
    end

    // R8: idle cycles hold the result
    for (int i = 0; i < 6; i++) apply(0, rnd_vec(), rnd_pred(), i % 4, "R8 hold");
    // R7: alternating valid
    for (int i = 0; i < 20; i++) apply(i % 2 == 0, rnd_vec(), rnd_pred(), i % 4, "R7 valid timing");
    // R3: long mixed run
    for (int i = 0; i < 2000; i++)
      apply($urandom_range(0, 3) != 0, rnd_vec(), rnd_pred(), $urandom_range(0, 3), "R3 mixed");

    // R9: reset in mid-stream
    apply(1, rnd_vec(), '1, 0, "R9 before reset");
    rst = 1'b1; in_valid = 1'b1; in_src = rnd_vec(); in_pred = '1;
    exp_valid = 1'b0; exp_vec = '0;
    @(negedge clk);
    check("R9 mid-run reset");
    rst = 1'b0;
    apply(1, rnd_vec(), rnd_pred(), 2, "R7 after reset");
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 200000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule